// File: doc/BRIEF.md
# Resynchronizing Serial Sample-Clock Generator

This block produces the bit clock and the internal frame-sync strobe for a multichannel serial port from one external source clock. It divides the source clock by a programmable ratio plus one. A ratio of zero passes the source clock straight through (single-rate clocking). The block watches an external frame-sync input. When that input changes from inactive to active, the block restarts the divider so that the bit clock realigns to the frame. It then issues an internal frame-sync pulse that is one full bit period long, so the receive and transmit sections can capture it on the falling edge of the bit clock.

A frame-sync polarity select allows either active-high or active-low external sync. An edge select chooses which source-clock edge drives all internal timing. In a typical frame the first bit (the MSB of word 1) shares its bit period with the sync, and a fixed number of words follows before the next sync.

Top module: `sclk_resync_gen`

## Requirements
- R1: With `div_ratio` = 0 and `clk_edge_sel` = 0, `bclk` follows `clk_src` directly: it is high while the source clock is high and low while it is low.
- R2: With `div_ratio` = r > 0, `bclk` is periodic with r+1 active source edges. The divider position is 0 at reset and at each realignment, and advances by one per active edge, wrapping to 0 after reaching r or more. `bclk` is high for positions below r/2+1 (integer division) and low otherwise. The high phase is therefore one edge longer than the low phase when r+1 is odd.
- R3: The external sync is sampled on each active source edge. Let edge k be the first edge at which it is sampled active after being sampled inactive. At edge k+1 the divider returns to position 0, so `bclk` starts a new high phase at that edge.
- R4: With `fs_pol` = 1 the external sync is active low; with `fs_pol` = 0 it is active high.
- R5: `fs_int` rises at edge k+1 and stays high for exactly r+1 active edges, where r is the divide ratio. It then goes low unless a new sync has been detected.
- R6: A sync detected while `fs_int` is still high restarts the pulse, so `fs_int` stays high for r+1 edges counted from the new detection.
- R7: While `rst` is high, `bclk` and `fs_int` are low (for every ratio), and the divider and the sync detector are cleared.
- R8: With `clk_edge_sel` = 1 every register is clocked on the falling edge of `clk_src`, and a ratio of 0 makes `bclk` the inverse of `clk_src`.
- R9: An external sync held active for many cycles produces only one detection. `fs_int` ends after r+1 edges while the sync is still held, and the divider keeps wrapping normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_ext | input | 1 | External frame-sync |
| div_ratio | input | RATIO_W (8) | Divide ratio r; bit clock = source/(r+1) |
| clk_edge_sel | input | 1 | 0: rising source edge is active; 1: falling edge |
| fs_pol | input | 1 | 0: sync active high; 1: sync active low |
| bclk | output | 1 | Generated bit clock |
| fs_int | output | 1 | Stretched internal frame-sync |

## Verification
The embedded properties check on every cycle four things: the divider position never exceeds a stable ratio; a detection always restarts a new high phase of the divided clock; the detector never fires on two consecutive edges; and the stretched pulse starts at the full length and drops once its count is spent. Other behaviour can only be shown by the bench scenarios. These are the exact realignment edge, the length of the pulse and its restart on a second sync, active-low sync, the clock pass-through at ratio zero for both edge selects, and the gating of the outputs during reset. The bench also runs an edge-by-edge model over random ratios, polarities and sync patterns.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic {
        FS_ACT_HIGH = 1'b0,
        FS_ACT_LOW  = 1'b1
    } fs_level_e;

    // Number of divider positions at which the bit clock is high.
    function automatic int unsigned high_span(int unsigned ratio);
        return ratio / 2 + 1;
    endfunction

endpackage

// File: rtl/sclk_fs_detect.sv
module sclk_fs_detect (
    input  logic clk,
    input  logic rst,
    input  logic fs_raw,
    input  logic pol,
    output logic det_o
);
    import sclk_pkg::*;

    typedef struct packed {
        logic smp;
        logic prev;
    } det_st_t;

    det_st_t st_d, st_q;
    logic    fs_act;

    always_comb begin
        fs_act  = (fs_level_e'(pol) == FS_ACT_LOW) ? ~fs_raw : fs_raw;
        st_d    = st_q;
        st_d.smp  = fs_act;
        st_d.prev = st_q.smp;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign det_o = st_q.smp & ~st_q.prev;

    // R9
    det_single_chk: assert property (@(posedge clk) disable iff (rst)
        det_o |=> !det_o);

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider #(
    parameter int unsigned RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               clr,
    output logic               bclk_o
);
    import sclk_pkg::*;

    localparam int unsigned CMP_W = RATIO_W + 1;

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               bclk;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic             wrap;
    logic [CMP_W-1:0] hi_len;

    always_comb begin
        hi_len = CMP_W'(high_span(int'(ratio)));
        wrap   = (st_q.cnt >= ratio);
        st_d   = st_q;
        if (clr || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.bclk = ({1'b0, st_d.cnt} < hi_len);
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bclk_o = st_q.bclk;

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(ratio) |-> (st_q.cnt <= ratio));

    // R3
    clr_start_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st_q.bclk && st_q.cnt == '0));

endmodule

// File: rtl/sclk_fs_stretch.sv
module sclk_fs_stretch #(
    parameter int unsigned RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trig,
    input  logic [RATIO_W-1:0] len,
    output logic               fs_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] left;
        logic               act;
    } str_st_t;

    str_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.left = len;
            st_d.act  = 1'b1;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
            st_d.act  = 1'b1;
        end else begin
            st_d.act  = 1'b0;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fs_o = st_q.act;

    // R5
    fs_start_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> (st_q.act && st_q.left == $past(len)));

    // R5
    fs_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig && st_q.left == '0) |=> !st_q.act);

endmodule

// File: rtl/sclk_resync_gen.sv
module sclk_resync_gen #(
    parameter int unsigned RATIO_W = 8
) (
    input  logic               clk_src,
    input  logic               rst,
    input  logic               fs_ext,
    input  logic [RATIO_W-1:0] div_ratio,
    input  logic               clk_edge_sel,
    input  logic               fs_pol,
    output logic               bclk,
    output logic               fs_int
);
    logic clk_eff;
    logic sync_det;
    logic div_bclk;
    logic pass_thru;

    // Active edge of the source clock becomes the rising edge of clk_eff.
    assign clk_eff   = clk_src ^ clk_edge_sel;
    assign pass_thru = (div_ratio == '0);

    sclk_fs_detect i_detect (
        .clk    (clk_eff),
        .rst    (rst),
        .fs_raw (fs_ext),
        .pol    (fs_pol),
        .det_o  (sync_det)
    );

    sclk_divider #(.RATIO_W(RATIO_W)) i_divider (
        .clk    (clk_eff),
        .rst    (rst),
        .ratio  (div_ratio),
        .clr    (sync_det),
        .bclk_o (div_bclk)
    );

    sclk_fs_stretch #(.RATIO_W(RATIO_W)) i_stretch (
        .clk  (clk_eff),
        .rst  (rst),
        .trig (sync_det),
        .len  (div_ratio),
        .fs_o (fs_int)
    );

    assign bclk = rst ? 1'b0 : (pass_thru ? clk_eff : div_bclk);

    // R3
    align_chk: assert property (@(posedge clk_eff) disable iff (rst)
        sync_det |=> (div_bclk && fs_int));

endmodule

// File: tb/test_sclk_resync_gen.sv
module test_sclk_resync_gen;

    logic       clk_src = 1'b0;
    logic       rst = 1'b1;
    logic       fs_ext = 1'b0;
    logic [7:0] div_ratio = 8'd3;
    logic       clk_edge_sel = 1'b0;
    logic       fs_pol = 1'b0;
    logic       bclk;
    logic       fs_int;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  mdl_on = 1'b0;
    logic ck_tb;

    always #4 clk_src = ~clk_src;
    assign ck_tb = clk_src ^ clk_edge_sel;

    sclk_resync_gen i_sclk_resync_gen (
        .clk_src      (clk_src),
        .rst          (rst),
        .fs_ext       (fs_ext),
        .div_ratio    (div_ratio),
        .clk_edge_sel (clk_edge_sel),
        .fs_pol       (fs_pol),
        .bclk         (bclk),
        .fs_int       (fs_int)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // drive point: middle of the cycle after the next active edge
    task automatic drv_wait();
        @(posedge ck_tb);
        #4;
    endtask

    // sample point: 2 ns after the next active edge
    task automatic smp_wait();
        @(posedge ck_tb);
        #2;
    endtask

    function automatic logic exp_high(input int pos, input int r);
        return pos < (r / 2 + 1);
    endfunction

    // Reference model built from R2..R6, R9
    int   m_pos = 0;
    int   m_left = 0;
    logic m_s1 = 0, m_s2 = 0, m_det, m_b = 0, m_f = 0;

    always @(posedge ck_tb) begin
        if (rst) begin
            m_pos = 0; m_left = 0; m_s1 = 0; m_s2 = 0; m_b = 0; m_f = 0;
        end else begin
            m_det = m_s1 & ~m_s2;
            m_s2  = m_s1;
            m_s1  = fs_ext ^ fs_pol;
            if (m_det || m_pos >= int'(div_ratio)) m_pos = 0;
            else m_pos = m_pos + 1;
            m_b = exp_high(m_pos, int'(div_ratio));
            if (m_det) begin
                m_left = int'(div_ratio); m_f = 1;
            end else if (m_left != 0) begin
                m_left = m_left - 1; m_f = 1;
            end else begin
                m_f = 0;
            end
        end
        #2;
        if (mdl_on) begin
            chk("R2", bclk, m_b);
            chk("R5", fs_int, m_f);
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1d2c);

        // R7: reset holds outputs low, including pass-through ratio
        repeat (3) drv_wait();
        @(posedge ck_tb); #2;
        chk("R7", bclk, 1'b0);
        chk("R7", fs_int, 1'b0);
        #2 div_ratio = 8'd0;
        @(posedge ck_tb); #2;
        chk("R7", bclk, 1'b0);

        // R1: ratio 0 passes the source clock through
        #2 rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            smp_wait();
            chk("R1", bclk, 1'b1);
            #4;
            chk("R1", bclk, 1'b0);
        end

        // R3: realignment, ratio 3
        #2 rst = 1'b1; div_ratio = 8'd3;
        drv_wait(); drv_wait();
        rst = 1'b0;
        repeat (5) drv_wait();
        fs_ext = 1'b1;
        drv_wait();
        fs_ext = 1'b0;
        smp_wait(); chk("R3", bclk, 1'b1); chk("R5", fs_int, 1'b1);
        smp_wait(); chk("R3", bclk, 1'b1); chk("R5", fs_int, 1'b1);
        smp_wait(); chk("R2", bclk, 1'b0); chk("R5", fs_int, 1'b1);
        smp_wait(); chk("R2", bclk, 1'b0); chk("R5", fs_int, 1'b1);
        smp_wait(); chk("R2", bclk, 1'b1); chk("R5", fs_int, 1'b0);

        // R4: active-low sync
        #2 fs_pol = 1'b1; fs_ext = 1'b1;
        repeat (6) drv_wait();
        fs_ext = 1'b0;
        drv_wait();
        fs_ext = 1'b1;
        smp_wait(); chk("R4", bclk, 1'b1); chk("R4", fs_int, 1'b1);
        repeat (3) smp_wait();
        chk("R4", fs_int, 1'b1);
        smp_wait(); chk("R4", fs_int, 1'b0); chk("R4", bclk, 1'b1);

        // R6: second sync restarts the stretched pulse, ratio 7
        #2 rst = 1'b1; fs_pol = 1'b0; fs_ext = 1'b0; div_ratio = 8'd7;
        drv_wait();
        rst = 1'b0;
        repeat (4) drv_wait();
        fs_ext = 1'b1;            // after e0
        drv_wait(); fs_ext = 1'b0; // after e1
        drv_wait();                // e2
        drv_wait(); fs_ext = 1'b1; // after e3
        drv_wait(); fs_ext = 1'b0; // after e4
        smp_wait(); chk("R6", fs_int, 1'b1); chk("R3", bclk, 1'b1); // e5
        repeat (6) smp_wait();     // e11
        chk("R6", fs_int, 1'b1);
        smp_wait(); chk("R6", fs_int, 1'b1); // e12
        smp_wait(); chk("R6", fs_int, 1'b0); // e13

        // R9: held sync gives a single pulse, divider keeps running, ratio 3
        #2 div_ratio = 8'd3;
        repeat (10) drv_wait();
        fs_ext = 1'b1;
        drv_wait();
        smp_wait(); chk("R9", fs_int, 1'b1); chk("R9", bclk, 1'b1); // e2
        repeat (3) smp_wait(); chk("R9", fs_int, 1'b1);             // e5
        smp_wait(); chk("R9", fs_int, 1'b0); chk("R9", bclk, 1'b1); // e6
        smp_wait(); smp_wait(); chk("R9", bclk, 1'b0);              // e8
        repeat (4) smp_wait(); chk("R9", fs_int, 1'b0);             // e12
        #2 fs_ext = 1'b0;

        // R8: falling-edge timing
        rst = 1'b1; clk_edge_sel = 1'b1; div_ratio = 8'd0;
        repeat (3) drv_wait();
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            smp_wait();
            chk("R8", bclk, 1'b1);
            chk("R8", clk_src, 1'b0);
            #4;
            chk("R8", bclk, 1'b0);
        end
        #2 div_ratio = 8'd3;
        repeat (6) drv_wait();
        fs_ext = 1'b1;
        drv_wait();
        fs_ext = 1'b0;
        smp_wait(); chk("R8", bclk, 1'b1); chk("R8", fs_int, 1'b1);
        smp_wait(); smp_wait(); chk("R8", bclk, 1'b0);
        smp_wait(); smp_wait(); chk("R8", bclk, 1'b1); chk("R8", fs_int, 1'b0);

        // Random scenarios against the model (R2, R5, R6)
        for (int sc = 0; sc < 14; sc++) begin
            #2 rst = 1'b1;
            mdl_on = 1'b0;
            clk_edge_sel = 1'($urandom_range(0, 1));
            fs_pol = 1'($urandom_range(0, 1));
            fs_ext = fs_pol;
            div_ratio = (sc == 0) ? 8'd0 : 8'($urandom_range(1, 12));
            repeat (3) drv_wait();
            rst = 1'b0;
            mdl_on = 1'b1;
            for (int c = 0; c < 300; c++) begin
                drv_wait();
                if ($urandom_range(0, 15) == 0)
                    fs_ext = ~fs_pol;
                else if ($urandom_range(0, 2) == 0)
                    fs_ext = fs_pol;
            end
            mdl_on = 1'b0;
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule